// File: doc/BRIEF.md
# CD Sector Decoder Host Transfer Controller

This block is the host-facing transfer engine of a CD-ROM sector decoder. A host reaches a small byte-wide register file through a 4-bit index on an 8-bit bus. The transfer byte count, the transfer source address, the write address and the block pointer are each held as a low and a high byte register. Interface control and interface status registers sit beside them, along with fixed header and status bytes.

Once a transfer has been armed and triggered, each strobe on the word-read input fetches two bytes from a 32 KB sector buffer through a synchronous byte-RAM port. The byte at the source address becomes the upper half of the word and the next byte becomes the lower half. The block then adds two to the address and subtracts two from the count, and writes both back into their byte registers. When the count runs out, the block pulses end-of-transfer and drops its active flag.

Several status bits change as side effects rather than through plain writes: reading the last status register, writing the acknowledge register, triggering a transfer, ending a transfer, and switching the transfer enable off.

Top module: `cdx_xfer_ctl`

## Requirements
- R1: After the reset pin is asserted, the count, write address and block pointer read back as 0x00 (read indices 2, 3, 8, 9, 10, 11). Interface status (read index 1) reads 0xFF, header byte 0 (read index 4) reads 0x01 and status 3 (read index 15) reads 0x80. No transfer is active.
- R2: Several register pairs are written through the write indices: count low/high at 1/2, write address low/high at 7/8 and block pointer low/high at 11/12. Each pair reads back unchanged through the read indices: count at 2/3, block pointer at 8/9 and write address at 10/11.
- R3: A word read returns buffer[src] in bits 15:8 and buffer[src+1] in bits 7:0. The source address is set through write indices 3/4. The buffer address is the low 15 bits of the sum, so it wraps at 32 KB. word_valid is a one-cycle pulse, three clocks after the clock edge that samples word_rd.
- R4: Each completed word read adds 2 to the 16-bit source address and subtracts 2 from the 16-bit count, modulo 2^16. The count that reads back through the count registers is the updated value.
- R5: If the count is 2 or less when a word completes, eot pulses for one cycle together with word_valid. In that case xfer_active clears and interface status bit 3 is set.
- R6: When a word ends the transfer and dest_sub is high, the count becomes 0. When dest_sub is low, the count wraps (for example, 1 becomes 0xFFFF and 0 becomes 0xFFFE).
- R7: A write to interface control (write index 0) with bit 1 clear zeroes both count bytes, stops any active transfer and sets interface status bit 3.
- R8: A write to the trigger register (write index 5) starts a transfer only when the last interface control write had bit 1 set. An accepted trigger clears interface status bits 6, 5 and 3. A trigger that is not accepted changes nothing.
- R9: A write to the acknowledge register (write index 6) sets interface status bit 6.
- R10: A read of status 3 (read index 15) returns 0x80 and sets interface status bit 5 as a side effect.
- R11: A write to write index 15 has the same effect as the reset pin.
- R12: A word_rd strobe while no transfer is active, or while a fetch is in progress, is ignored. No word_valid pulse follows and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 4 | Register index for host reads and writes |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (side effects) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for reg_idx (combinational) |
| dest_sub | input | 1 | Current destination is the sub-processor read path |
| word_rd | input | 1 | Request one 16-bit word from the buffer |
| word_data | output | 16 | Fetched big-endian word |
| word_valid | output | 1 | One-cycle pulse when word_data is new |
| eot | output | 1 | One-cycle end-of-transfer pulse |
| xfer_active | output | 1 | A triggered transfer is in progress |
| buf_addr | output | 15 | Sector buffer byte address |
| buf_rdata | input | 8 | Buffer byte, one cycle after buf_addr |

## Verification
The hardest situation to reach from the ports is a word that completes with a count of 2 or less. The outcome then depends on dest_sub, and the count either wraps or is forced to zero. The stimulus table loads a source address and a count through the byte registers, arms and triggers a transfer, and issues one word read. It covers counts of 0, 1, 2 and 3, both destinations, an odd address, and an address of 0x7FFF, which makes the second byte fetch wrap the buffer address. Directed tests then reach the status side effects. They switch the transfer off mid-transfer, send a trigger while disarmed, and strobe a word read while idle.

// File: rtl/cdx_xfer_ctl.sv
module cdx_xfer_ctl #(
  parameter int BUF_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_idx,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              dest_sub,
  input  logic              word_rd,
  output logic [15:0]       word_data,
  output logic              word_valid,
  output logic              eot,
  output logic              xfer_active,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata
);
  localparam logic [3:0] W_IFCTL = 4'd0, W_CNTL = 4'd1, W_CNTH = 4'd2, W_SRCL = 4'd3,
                         W_SRCH = 4'd4, W_TRIG = 4'd5, W_ACK = 4'd6, W_WAL = 4'd7,
                         W_WAH = 4'd8, W_PTL = 4'd11, W_PTH = 4'd12, W_RST = 4'd15;
  localparam logic [3:0] R_IFSTAT = 4'd1, R_CNTL = 4'd2, R_CNTH = 4'd3, R_HDR0 = 4'd4,
                         R_PTL = 4'd8, R_PTH = 4'd9, R_WAL = 4'd10, R_WAH = 4'd11,
                         R_STAT3 = 4'd15;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_A = 2'd1, PH_B = 2'd2, PH_C = 2'd3;

  logic [15:0] cnt, src, wa, pt;
  logic [7:0]  ifstat, hi_byte;
  logic        xfer_en;
  logic [1:0]  phase;

  wire soft_rst  = wr_en && reg_idx == W_RST;
  wire last_word = cnt <= 16'd2;

  assign buf_addr = src[BUF_AW-1:0] + ((phase == PH_B) ? BUF_AW'(1) : BUF_AW'(0));

  always_comb begin
    case (reg_idx)
      R_IFSTAT: rdata = ifstat;
      R_CNTL:   rdata = cnt[7:0];
      R_CNTH:   rdata = cnt[15:8];
      R_HDR0:   rdata = 8'h01;
      R_PTL:    rdata = pt[7:0];
      R_PTH:    rdata = pt[15:8];
      R_WAL:    rdata = wa[7:0];
      R_WAH:    rdata = wa[15:8];
      R_STAT3:  rdata = 8'h80;
      default:  rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; src <= '0; wa <= '0; pt <= '0;
      ifstat <= 8'hFF; hi_byte <= '0; xfer_en <= 1'b0; xfer_active <= 1'b0;
      phase <= PH_IDLE; word_data <= '0; word_valid <= 1'b0; eot <= 1'b0;
    end else if (soft_rst) begin
      cnt <= '0; src <= '0; wa <= '0; pt <= '0;
      ifstat <= 8'hFF; hi_byte <= '0; xfer_en <= 1'b0; xfer_active <= 1'b0;
      phase <= PH_IDLE; word_data <= '0; word_valid <= 1'b0; eot <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      eot        <= 1'b0;
      case (phase)
        PH_IDLE: if (word_rd && xfer_active) phase <= PH_A;
        PH_A:    phase <= PH_B;
        PH_B:    begin hi_byte <= buf_rdata; phase <= PH_C; end
        PH_C: begin
          phase      <= PH_IDLE;
          word_data  <= {hi_byte, buf_rdata};
          word_valid <= 1'b1;
          src        <= src + 16'd2;
          cnt        <= (last_word && dest_sub) ? 16'd0 : cnt - 16'd2;
          if (last_word) begin
            eot         <= 1'b1;
            xfer_active <= 1'b0;
            ifstat[3]   <= 1'b1;
          end
        end
      endcase
      if (rd_en && reg_idx == R_STAT3) ifstat[5] <= 1'b1;
      if (wr_en) begin
        case (reg_idx)
          W_IFCTL: begin
            xfer_en <= wdata[1];
            if (!wdata[1]) begin
              cnt <= '0; xfer_active <= 1'b0; phase <= PH_IDLE; ifstat[3] <= 1'b1;
            end
          end
          W_CNTL: cnt[7:0]  <= wdata;
          W_CNTH: cnt[15:8] <= wdata;
          W_SRCL: src[7:0]  <= wdata;
          W_SRCH: src[15:8] <= wdata;
          W_TRIG: if (xfer_en) begin
            xfer_active <= 1'b1;
            ifstat[6] <= 1'b0; ifstat[5] <= 1'b0; ifstat[3] <= 1'b0;
          end
          W_ACK:  ifstat[6] <= 1'b1;
          W_WAL:  wa[7:0]  <= wdata;
          W_WAH:  wa[15:8] <= wdata;
          W_PTL:  pt[7:0]  <= wdata;
          W_PTH:  pt[15:8] <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

module cdx_xfer_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  reg_idx,
  input logic [7:0]  wdata,
  input logic        word_valid,
  input logic        eot,
  input logic        xfer_active,
  input logic [15:0] cnt
);
  p_eot_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (word_valid && !xfer_active));
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  p_ifctl_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 4'd0 && !wdata[1]) |=> (!xfer_active && cnt == 16'd0));
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 4'd15) |=> (!xfer_active && cnt == 16'd0));
  p_word_needs_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(xfer_active));
endmodule

bind cdx_xfer_ctl cdx_xfer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx), .wdata(wdata),
  .word_valid(word_valid), .eot(eot), .xfer_active(xfer_active), .cnt(cnt)
);

// File: tb/test_cdx_xfer_ctl.sv
module test_cdx_xfer_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_idx = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, dest_sub = 1'b0, word_rd = 1'b0;
  logic [7:0] wdata = '0, rdata, buf_rdata;
  logic [15:0] word_data;
  logic word_valid, eot, xfer_active;
  logic [14:0] buf_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cdx_xfer_ctl i_cdx_xfer_ctl (.*);

  function automatic logic [7:0] mem_fn(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0};
  endfunction
  always_ff @(posedge clk) buf_rdata <= mem_fn(buf_addr);

  // {src, count, dest_sub, expected count after, expected eot}
  localparam logic [49:0] VEC [7] = '{
    {16'h0010, 16'h0100, 1'b0, 16'h00FE, 1'b0},
    {16'h7FFF, 16'h0003, 1'b0, 16'h0001, 1'b0},
    {16'h1234, 16'h0002, 1'b0, 16'h0000, 1'b1},
    {16'h0100, 16'h0001, 1'b1, 16'h0000, 1'b1},
    {16'h0200, 16'h0001, 1'b0, 16'hFFFF, 1'b1},
    {16'h4ABC, 16'h0000, 1'b0, 16'hFFFE, 1'b1},
    {16'h0ABD, 16'h8000, 1'b1, 16'h7FFE, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); reg_idx = i; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] d);
    @(negedge clk); reg_idx = i; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] a, b;
    rd(lo, a); rd(lo + 4'd1, b); v = {b, a};
  endtask

  // returns sampled valid/eot one negedge after the third edge following the strobe
  task automatic word(output logic v, output logic e, output logic [15:0] d);
    @(negedge clk); word_rd = 1'b1;
    @(negedge clk); word_rd = 1'b0;
    repeat (3) @(negedge clk);
    v = word_valid; e = eot; d = word_data;
  endtask

  task automatic arm(input logic [15:0] s, input logic [15:0] c);
    wr(4'd3, s[7:0]); wr(4'd4, s[15:8]);
    wr(4'd1, c[7:0]); wr(4'd2, c[15:8]);
    wr(4'd0, 8'h02); wr(4'd5, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b; logic [15:0] w, c; logic v, e;
    repeat (3) @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(4'd1, b); check("R1 ifstat", b, 8'hFF);
    rd16(4'd2, w); check("R1 count", w, 16'h0);
    rd16(4'd8, w); check("R1 pointer", w, 16'h0);
    rd16(4'd10, w); check("R1 waddr", w, 16'h0);
    rd(4'd4, b); check("R1 hdr0", b, 8'h01);
    rd(4'd15, b); check("R1 stat3", b, 8'h80);
    check("R1 active", xfer_active, 1'b0);

    // R2 readback
    wr(4'd11, 8'h5A); wr(4'd12, 8'h3C); rd16(4'd8, w); check("R2 pointer", w, 16'h3C5A);
    wr(4'd7, 8'hA5); wr(4'd8, 8'h71); rd16(4'd10, w); check("R2 waddr", w, 16'h71A5);
    wr(4'd1, 8'h34); wr(4'd2, 8'h92); rd16(4'd2, w); check("R2 count", w, 16'h9234);

    // R11 soft reset
    wr(4'd15, 8'h00);
    rd16(4'd8, w); check("R11 pointer", w, 16'h0);
    rd16(4'd10, w); check("R11 waddr", w, 16'h0);
    rd16(4'd2, w); check("R11 count", w, 16'h0);
    rd(4'd1, b); check("R11 ifstat", b, 8'hFF);

    // R3 R4 R5 R6 vector table
    foreach (VEC[k]) begin
      logic [15:0] s, c0, ce; logic sub, ee;
      {s, c0, sub, ce, ee} = VEC[k];
      dest_sub = sub;
      arm(s, c0);
      check("R8 trigger accepted", xfer_active, 1'b1);
      word(v, e, w);
      check("R3 word valid", v, 1'b1);
      check("R3 word data", w, {mem_fn(s[14:0]), mem_fn(s[14:0] + 15'd1)});
      check("R5 eot", e, ee);
      check("R5 active after", xfer_active, !ee);
      rd16(4'd2, c); check("R4 R6 count after", c, ce);
      rd(4'd1, b); check("R5 ifstat bit3", b[3], ee);
    end
    dest_sub = 1'b0;

    // R4 address advance across two words
    arm(16'h0300, 16'h0010);
    word(v, e, w);
    word(v, e, w);
    check("R4 second word", w, {mem_fn(15'h0302), mem_fn(15'h0303)});
    rd16(4'd2, c); check("R4 count twice", c, 16'h000C);

    // R10 status 3 read side effect (ifstat 0x97 after trigger)
    rd(4'd1, b); check("R8 ifstat after trigger", b, 8'h97);
    rd(4'd15, b); check("R10 stat3 value", b, 8'h80);
    rd(4'd1, b); check("R10 ifstat bit5", b, 8'hB7);
    // R9 acknowledge
    wr(4'd6, 8'h00); rd(4'd1, b); check("R9 ifstat bit6", b, 8'hF7);

    // R7 disable mid transfer
    wr(4'd0, 8'h00);
    check("R7 active", xfer_active, 1'b0);
    rd16(4'd2, c); check("R7 count", c, 16'h0);
    rd(4'd1, b); check("R7 ifstat bit3", b, 8'hFF);

    // R8 trigger while disarmed
    wr(4'd15, 8'h00);
    wr(4'd1, 8'h20); wr(4'd0, 8'h00); wr(4'd1, 8'h20);
    wr(4'd5, 8'h00);
    check("R8 no start", xfer_active, 1'b0);
    rd(4'd1, b); check("R8 ifstat kept", b, 8'hFF);

    // R12 word read while idle
    word(v, e, w);
    check("R12 no valid", v, 1'b0);
    rd16(4'd2, c); check("R12 count kept", c, 16'h0020);

    // R12 strobe during a fetch is ignored
    arm(16'h0040, 16'h0008);
    @(negedge clk); word_rd = 1'b1;
    repeat (2) @(negedge clk); word_rd = 1'b0;
    repeat (4) @(negedge clk);
    rd16(4'd2, c); check("R12 busy strobe", c, 16'h0006);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule